// File: doc/BRIEF.md
# Histogram Adaptive Threshold Selector

This block collects statistics on the correlation scores produced while one matching point is searched, and turns them into a pass threshold for the next point. Each valid score is sorted into one of 100 equal bins spanning 0 to 1 and counts up that bin. When the search-done pulse arrives, the block stops taking scores. It then walks the bins from the top one down, summing their counts. It stops at the first bin where the running sum covers the configured share of all scores seen.

The index of that bin is the new threshold. It is given out with a one-cycle valid pulse and stays on the output until the next result. All bin counts are then cleared, ready for the next point. A larger share lets more candidates through and so moves the threshold down.

Top module: `hist_thresh_sel`

## Requirements
- R1: `coef_in` is an unsigned fixed-point value with 14 fraction bits, so 16384 stands for 1.0. For values below 1.0 the bin index is floor(coef_in × 100 / 16384). For example, 3276 lands in bin 19, 3277 in bin 20 and 16383 in bin 99.
- R2: A score at or above 1.0 (coef_in ≥ 16384, up to 65535) is counted in bin 99.
- R3: Each cycle with `coef_vld` high adds one to the count of that score's bin. A score presented in the same cycle as `search_done` is still counted.
- R4: After `search_done`, the threshold is the highest bin b at which 100 × (sum of counts in bins 99 down to b) ≥ pct × total count. The test is inclusive, so an exact match stops the scan.
- R5: The share `cfg_pct` is a whole percentage. Values above 100 act as 100. A value of 0 yields bin 99. A higher share never yields a higher bin.
- R6: If no score arrived since the last result, the threshold is bin 0.
- R7: `thr_valid` is high for exactly one cycle per `search_done`, within 104 cycles of the pulse. `thr_bin` keeps that value until the next result.
- R8: All bin counts and the total clear as the result is issued, so each search is independent of earlier ones.
- R9: After reset, `thr_valid` is 0 and `thr_bin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_in | input | 16 | Correlation score, unsigned, 14 fraction bits |
| coef_vld | input | 1 | Score on `coef_in` is valid this cycle |
| search_done | input | 1 | One-cycle pulse ending the current point's search |
| cfg_pct | input | 7 | Share of all scores, in percent, that sets the threshold |
| thr_bin | output | 7 | Threshold bin index, 0 to 99 |
| thr_valid | output | 1 | One-cycle pulse when `thr_bin` is updated |

## Verification
The assertions assume three things about the inputs. No score arrives from the cycle after `search_done` until `thr_valid` has pulsed. `cfg_pct` holds steady while the bins are being walked. `search_done` is not raised again before the previous result is out. The stimulus drives every score and the done pulse on the falling edge. Before it sends the next point's scores, it waits for the valid pulse plus a few idle cycles, and it changes the percentage only between points. The scores chosen sit just above and just below bin edges, at exactly 1.0, and at the top of the input range. The shares chosen land exactly on the inclusive stop test.

// File: rtl/hts_pkg.sv
package hts_pkg;

    // Default geometry of the selector
    localparam int unsigned HTS_COEF_W    = 16;
    localparam int unsigned HTS_FRAC_W    = 14;
    localparam int unsigned HTS_NUM_BINS  = 100;
    localparam int unsigned HTS_CNT_W     = 16;
    localparam int unsigned HTS_PCT_W     = 7;
    localparam int unsigned HTS_PCT_SCALE = 100;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE,   // collecting scores
        ST_ARM,    // last score settles into the bank
        ST_SCAN,   // one bin per cycle, high to low
        ST_DONE    // result issued, bank clears
    } scan_state_t;

    // Maps an unsigned fixed-point score onto its bin; saturates at the top bin
    function automatic int unsigned coef_to_bin(longint unsigned v,
                                                int unsigned frac,
                                                int unsigned nbins);
        longint unsigned one_q;
        longint unsigned scaled;
        one_q  = longint'(1) << frac;
        if (v >= one_q) begin
            return nbins - 1;
        end
        scaled = (v * longint'(nbins)) >> frac;
        return int'(scaled);
    endfunction

    // Limits a percentage to the scale
    function automatic int unsigned clamp_pct(int unsigned p, int unsigned scale);
        return (p > scale) ? scale : p;
    endfunction

endpackage

// File: rtl/hts_binner.sv
module hts_binner #(
    parameter int unsigned COEF_W   = hts_pkg::HTS_COEF_W,
    parameter int unsigned FRAC_W   = hts_pkg::HTS_FRAC_W,
    parameter int unsigned NUM_BINS = hts_pkg::HTS_NUM_BINS,
    parameter int unsigned BIN_W    = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COEF_W-1:0] coef,
    input  logic              coef_vld,
    input  logic              done_in,
    output logic              smp_vld,
    output logic [BIN_W-1:0]  smp_bin,
    output logic              done_q
);

    logic [BIN_W-1:0] bin_c;

    always_comb begin
        bin_c = BIN_W'(hts_pkg::coef_to_bin(64'(coef), FRAC_W, NUM_BINS));
    end

    // Score and done travel through the same stage so their order is kept
    always_ff @(posedge clk) begin
        if (rst) begin
            smp_vld <= 1'b0;
            smp_bin <= '0;
            done_q  <= 1'b0;
        end else begin
            smp_vld <= coef_vld;
            smp_bin <= bin_c;
            done_q  <= done_in;
        end
    end

    AST_BIN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> (int'(smp_bin) < int'(NUM_BINS))); // R1

endmodule

// File: rtl/hts_bank.sv
module hts_bank #(
    parameter int unsigned NUM_BINS = hts_pkg::HTS_NUM_BINS,
    parameter int unsigned CNT_W    = hts_pkg::HTS_CNT_W,
    parameter int unsigned BIN_W    = $clog2(NUM_BINS),
    parameter int unsigned TOT_W    = CNT_W + $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_en,
    input  logic             inc_vld,
    input  logic [BIN_W-1:0] inc_bin,
    input  logic             clr,
    input  logic [BIN_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [TOT_W-1:0] total
);

    logic [CNT_W-1:0]    cnt_q [NUM_BINS];
    logic [NUM_BINS-1:0] hit;

    // One saturating counter per bin
    for (genvar b = 0; b < int'(NUM_BINS); b++) begin : g_bin
        assign hit[b] = acc_en && inc_vld && (inc_bin == BIN_W'(b))
                        && (cnt_q[b] != {CNT_W{1'b1}});
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt_q[b] <= '0;
            end else if (hit[b]) begin
                cnt_q[b] <= cnt_q[b] + 1'b1;
            end
        end
    end

    // The total only grows with a bin, so a full walk always reaches it
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            total <= '0;
        end else if (|hit) begin
            total <= total + 1'b1;
        end
    end

    always_comb begin
        rd_cnt = (int'(rd_idx) < int'(NUM_BINS)) ? cnt_q[rd_idx] : '0;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (total == '0)); // R8
    AST_FROZEN_WHILE_WALKING: assert property (@(posedge clk) disable iff (rst)
        (!acc_en && !clr) |=> $stable(total)); // R3

endmodule

// File: rtl/hts_scan.sv
module hts_scan #(
    parameter int unsigned NUM_BINS  = hts_pkg::HTS_NUM_BINS,
    parameter int unsigned CNT_W     = hts_pkg::HTS_CNT_W,
    parameter int unsigned PCT_W     = hts_pkg::HTS_PCT_W,
    parameter int unsigned PCT_SCALE = hts_pkg::HTS_PCT_SCALE,
    parameter int unsigned BIN_W     = $clog2(NUM_BINS),
    parameter int unsigned TOT_W     = CNT_W + $clog2(NUM_BINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PCT_W-1:0] pct,
    input  logic [TOT_W-1:0] total,
    input  logic [CNT_W-1:0] rd_cnt,
    output logic [BIN_W-1:0] rd_idx,
    output logic             acc_en,
    output logic             clr,
    output logic [BIN_W-1:0] thr_bin,
    output logic             thr_valid
);
    import hts_pkg::*;

    localparam int unsigned PROD_W = TOT_W + $clog2(PCT_SCALE + 1);

    scan_state_t      state;
    logic [TOT_W-1:0] sum_q;
    logic [TOT_W-1:0] sum_next;
    logic [PCT_W-1:0] pct_eff;
    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;
    logic             reached;

    // Division-free stop test: scale * running sum against share * total
    always_comb begin
        pct_eff  = PCT_W'(clamp_pct(int'(pct), PCT_SCALE));
        sum_next = sum_q + TOT_W'(rd_cnt);
        lhs      = PROD_W'(sum_next) * PROD_W'(PCT_SCALE);
        rhs      = PROD_W'(pct_eff) * PROD_W'(total);
        reached  = (lhs >= rhs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sum_q   <= '0;
            rd_idx  <= '0;
            thr_bin <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_ARM;
                end
                ST_ARM: begin
                    if (total == '0) begin
                        thr_bin <= '0;
                        state   <= ST_DONE;
                    end else begin
                        rd_idx <= BIN_W'(NUM_BINS - 1);
                        sum_q  <= '0;
                        state  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    sum_q <= sum_next;
                    if (reached || rd_idx == '0) begin
                        thr_bin <= rd_idx;
                        state   <= ST_DONE;
                    end else begin
                        rd_idx <= rd_idx - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign acc_en    = (state == ST_IDLE);
    assign clr       = (state == ST_DONE);
    assign thr_valid = (state == ST_DONE);

    AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
        thr_valid |=> !thr_valid); // R7
    AST_WALK_DESCENDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN && $past(state) == ST_SCAN) |-> (rd_idx == $past(rd_idx) - 1'b1)); // R4
    AST_SUM_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN) |-> (sum_q <= total)); // R4
    AST_EMPTY_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARM && total == '0) |=> (thr_bin == '0)); // R6
    AST_THR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        thr_valid |-> (int'(thr_bin) < int'(NUM_BINS))); // R4
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(thr_bin)); // R7

endmodule

// File: rtl/hist_thresh_sel.sv
module hist_thresh_sel #(
    parameter int unsigned COEF_W    = hts_pkg::HTS_COEF_W,
    parameter int unsigned FRAC_W    = hts_pkg::HTS_FRAC_W,
    parameter int unsigned NUM_BINS  = hts_pkg::HTS_NUM_BINS,
    parameter int unsigned CNT_W     = hts_pkg::HTS_CNT_W,
    parameter int unsigned PCT_W     = hts_pkg::HTS_PCT_W,
    parameter int unsigned PCT_SCALE = hts_pkg::HTS_PCT_SCALE,
    parameter int unsigned BIN_W     = $clog2(NUM_BINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COEF_W-1:0] coef_in,
    input  logic              coef_vld,
    input  logic              search_done,
    input  logic [PCT_W-1:0]  cfg_pct,
    output logic [BIN_W-1:0]  thr_bin,
    output logic              thr_valid
);

    localparam int unsigned TOT_W = CNT_W + $clog2(NUM_BINS);

    logic             smp_vld;
    logic [BIN_W-1:0] smp_bin;
    logic             done_q;
    logic             acc_en;
    logic             clr;
    logic [BIN_W-1:0] rd_idx;
    logic [CNT_W-1:0] rd_cnt;
    logic [TOT_W-1:0] total;

    hts_binner #(
        .COEF_W(COEF_W), .FRAC_W(FRAC_W), .NUM_BINS(NUM_BINS), .BIN_W(BIN_W)
    ) i_binner (
        .clk(clk), .rst(rst), .coef(coef_in), .coef_vld(coef_vld),
        .done_in(search_done), .smp_vld(smp_vld), .smp_bin(smp_bin), .done_q(done_q)
    );

    hts_bank #(
        .NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .BIN_W(BIN_W), .TOT_W(TOT_W)
    ) i_bank (
        .clk(clk), .rst(rst), .acc_en(acc_en), .inc_vld(smp_vld), .inc_bin(smp_bin),
        .clr(clr), .rd_idx(rd_idx), .rd_cnt(rd_cnt), .total(total)
    );

    hts_scan #(
        .NUM_BINS(NUM_BINS), .CNT_W(CNT_W), .PCT_W(PCT_W), .PCT_SCALE(PCT_SCALE),
        .BIN_W(BIN_W), .TOT_W(TOT_W)
    ) i_scan (
        .clk(clk), .rst(rst), .start(done_q), .pct(cfg_pct), .total(total),
        .rd_cnt(rd_cnt), .rd_idx(rd_idx), .acc_en(acc_en), .clr(clr),
        .thr_bin(thr_bin), .thr_valid(thr_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !thr_valid); // R9

endmodule

// File: tb/test_hist_thresh_sel.sv
module test_hist_thresh_sel;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] coef_in;
    logic        coef_vld;
    logic        search_done;
    logic [6:0]  cfg_pct;
    logic [6:0]  thr_bin;
    logic        thr_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hist_thresh_sel i_hist_thresh_sel (
        .clk(clk), .rst(rst), .coef_in(coef_in), .coef_vld(coef_vld),
        .search_done(search_done), .cfg_pct(cfg_pct),
        .thr_bin(thr_bin), .thr_valid(thr_valid)
    );

    // hi_n scores of hi_v, lo_n of lo_v, share, expected threshold
    typedef struct packed {
        int hi_n; int hi_v; int lo_n; int lo_v; int pct; int exp_bin;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{10, 14746, 90, 3277,   8, 90},  // R4 top bin alone covers the share
        '{ 5, 14746, 95, 3277,   8, 20},  // R4 falls through to lower bin
        '{ 8, 14746, 92, 3277,   8, 90},  // R4 exact equality stops
        '{10, 14746, 90, 3277,  50, 20},  // R5 larger share, lower bin
        '{ 3, 11469,  7,  820, 100,  5},  // R5 full share reaches last occupied bin
        '{ 4,  4916,  4, 1639,   0, 99},  // R5 zero share
        '{ 2,  6554,  2, 6554, 127, 40},  // R5 share above 100 acts as 100
        '{ 1,  3276,  0,    0, 100, 19},  // R1 just below a bin edge
        '{ 2, 16383, 18,    0,  10, 99},  // R1 largest value below 1.0
        '{ 1, 65535,  4,    0,  20, 99}   // R2 top of input range
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int n, input int v);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            coef_in  = 16'(v);
            coef_vld = 1'b1;
        end
        @(negedge clk);
        coef_vld = 1'b0;
    endtask

    // Pulses done, waits for the result, checks value, pulse width and hold
    task automatic finish_point(input int exp_bin, input string req, input bit with_sample, input int v);
        int lat;
        bit seen;
        @(negedge clk);
        search_done = 1'b1;
        if (with_sample) begin
            coef_in  = 16'(v);
            coef_vld = 1'b1;
        end
        @(negedge clk);
        search_done = 1'b0;
        coef_vld    = 1'b0;
        seen = 1'b0;
        lat  = 1;
        for (int k = 0; k < 110 && !seen; k++) begin
            if (thr_valid) seen = 1'b1;
            else begin
                @(negedge clk);
                lat++;
            end
        end
        check(seen && lat <= 104, "R7 latency", lat, 104);
        check(int'(thr_bin) == exp_bin, req, int'(thr_bin), exp_bin);
        @(negedge clk);
        check(!thr_valid, "R7 pulse width", int'(thr_valid), 0);
        check(int'(thr_bin) == exp_bin, "R7 hold", int'(thr_bin), exp_bin);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; coef_in = '0; coef_vld = 1'b0; search_done = 1'b0; cfg_pct = 7'd8;
        repeat (3) @(negedge clk);
        check(!thr_valid, "R9 valid", int'(thr_valid), 0);
        check(thr_bin == 7'd0, "R9 bin", int'(thr_bin), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!thr_valid, "R9 idle after reset", int'(thr_valid), 0);

        for (int i = 0; i < NVEC; i++) begin
            cfg_pct = 7'(VECS[i].pct);
            send(VECS[i].hi_n, VECS[i].hi_v);
            send(VECS[i].lo_n, VECS[i].lo_v);
            finish_point(VECS[i].exp_bin, $sformatf("R4 vector %0d", i), 1'b0, 0);
        end

        // R2: exactly 1.0
        cfg_pct = 7'd20;
        send(1, 16384);
        send(4, 0);
        finish_point(99, "R2 value of 1.0", 1'b0, 0);

        // R6 and R8: nothing since last result, earlier counts must be gone
        cfg_pct = 7'd8;
        finish_point(0, "R6 R8 empty point", 1'b0, 0);

        // R3: lone score alongside the done pulse (8192 is bin 50)
        cfg_pct = 7'd100;
        finish_point(50, "R3 score with done", 1'b1, 8192);

        // R1 at a bin edge exactly
        send(3, 3277);
        finish_point(20, "R1 edge value", 1'b0, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule